// File: doc/BRIEF.md
# Deadlock Recovery Watchdog

This block guards the control state machine of a low-power timekeeping device against lock-up. A timeout counter advances on a one-cycle 1 Hz tick from the prescaler. A periodic heartbeat from the control state machine clears it. If the heartbeat stops for two monitoring periods, the block issues a one-cycle reset to the control logic only. The watch, alarm and timer state is never touched by this reset. In the cycle after the reset, it pulses a restart request so that the power-up sequence runs again.

A period-select input picks the monitoring period, which is 1 s or 16 s. The timeout window is therefore 2 or 32 ticks. The block holds four control and status bits: the watchdog enable, the interrupt enable, a sticky trip status and an interrupt flag. They are written through a 4-bit write port and are always visible on a 4-bit read port. The interrupt request follows the flag.

Top module: `selfheal_wdog`

## Requirements
- R1: After power-up reset, `rdData` reads 4'b0001, and `ctlRst`, `restartPulse` and `irq` are low. The bit positions are: bit 0 enable, bit 1 interrupt enable, bit 2 trip status, bit 3 interrupt flag.
- R2: While enabled, the tick that is number W without any heartbeat since the last clear makes `ctlRst` high in the cycle after that tick. W is 2 when `longPeriod`=0 and 32 when `longPeriod`=1. Fewer ticks do not fire.
- R3: A heartbeat clears the counter. A heartbeat in the same cycle as a tick wins, so the count is zero after that cycle.
- R4: `ctlRst` is high for exactly one cycle. `restartPulse` is high for exactly the one following cycle, and the two are never high together.
- R5: After a trip, the trip status bit reads 1, the enable reads 1 and the interrupt enable reads 0.
- R6: A trip sets the interrupt flag if the interrupt enable was 1 when the watchdog fired; otherwise the flag is unchanged. `irq` equals the flag.
- R7: With enable at 0 the counter is held at zero and no tick causes a trip. After enable is set again, the full window of W ticks is needed.
- R8: Writing 0 to bit 3 clears the flag. Writing 1 to bit 3 leaves it unchanged.
- R9: Writing 0 to bit 2 clears the trip status only if the flag was already 0 before that write. Writing 1 to bit 2 leaves it unchanged.
- R10: Ticks and heartbeats during the `ctlRst` and `restartPulse` cycles are ignored. The counter restarts from zero after the restart pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous power-up reset, active low |
| tick | input | 1 | One-cycle 1 Hz tick from the prescaler |
| heartbeat | input | 1 | Liveness pulse from the control state machine |
| longPeriod | input | 1 | Monitoring period select: 0 = 1 s, 1 = 16 s |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 4 | Write data, same bit layout as rdData |
| rdData | output | 4 | Current enable, interrupt enable, status and flag |
| ctlRst | output | 1 | One-cycle reset for the control logic |
| restartPulse | output | 1 | One-cycle request to rerun the power-up sequence |
| irq | output | 1 | Interrupt request, high while the flag is set |

## Verification
The assertions assume that writes and ticks are only meaningful while the block is armed. Writes that land in the reset or restart cycle are dropped, so the properties about what follows a trip hold regardless. The bench never writes during those two cycles, and it drives every input on the falling clock edge as a one-cycle pulse. The assertions also assume that the flag can rise only through a trip, and the stimulus holds to this because it never raises the flag through any other path. The bench changes `longPeriod` only while the counter is at zero, right after a heartbeat. That keeps the expected window unambiguous.

// File: rtl/selfheal_pkg.sv
package selfheal_pkg;
  localparam int REG_W  = 4;
  localparam int EN_BIT = 0;
  localparam int IE_BIT = 1;
  localparam int ST_BIT = 2;
  localparam int FL_BIT = 3;

  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_FIRE    = 2'd1,
    ST_RESTART = 2'd2
  } wdState_e;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic applyTrip;
    logic allowWrite;
  } dpStrobe_t;
endpackage

// File: rtl/selfheal_dp.sv
module selfheal_dp
  import selfheal_pkg::*;
#(
  parameter int SHORT_PERIOD_TICKS = 1,
  parameter int LONG_PERIOD_TICKS  = 16,
  parameter int WINDOW_PERIODS     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             longPeriod,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic             atLast,
  output logic             enable,
  output logic [REG_W-1:0] regView
);
  localparam int SHORT_WIN = SHORT_PERIOD_TICKS * WINDOW_PERIODS;
  localparam int LONG_WIN  = LONG_PERIOD_TICKS * WINDOW_PERIODS;
  localparam int MAX_WIN   = (LONG_WIN > SHORT_WIN) ? LONG_WIN : SHORT_WIN;
  localparam int CNT_W     = $clog2(MAX_WIN + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_WIN - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_WIN - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastTick;
  logic enReg, ieReg, stReg, flReg;

  assign lastTick = longPeriod ? LONG_LAST : SHORT_LAST;
  // >= keeps a shortened window safe if the select changes mid-count
  assign atLast   = (cnt >= lastTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.clrCnt) begin
      cnt <= '0;
    end else if (strobe.incCnt) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= 1'b1;
      ieReg <= 1'b0;
      stReg <= 1'b0;
      flReg <= 1'b0;
    end else if (strobe.applyTrip) begin
      enReg <= 1'b1;
      ieReg <= 1'b0;
      stReg <= 1'b1;
      flReg <= flReg | ieReg;
    end else if (wrEn && strobe.allowWrite) begin
      enReg <= wrData[EN_BIT];
      ieReg <= wrData[IE_BIT];
      if (!wrData[FL_BIT]) flReg <= 1'b0;
      // status clears only once the flag was already clear
      if (!wrData[ST_BIT] && !flReg) stReg <= 1'b0;
    end
  end

  assign enable = enReg;

  always_comb begin
    regView         = '0;
    regView[EN_BIT] = enReg;
    regView[IE_BIT] = ieReg;
    regView[ST_BIT] = stReg;
    regView[FL_BIT] = flReg;
  end
endmodule

// File: rtl/selfheal_ctrl.sv
module selfheal_ctrl
  import selfheal_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      heartbeat,
  input  logic      enable,
  input  logic      atLast,
  output dpStrobe_t strobe,
  output logic      ctlRst,
  output logic      restartPulse
);
  wdState_e state, stateNext;
  logic armed, fire;

  assign armed = (state == ST_ARMED);
  assign fire  = armed && enable && tick && !heartbeat && atLast;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_ARMED:   if (fire) stateNext = ST_FIRE;
      ST_FIRE:    stateNext = ST_RESTART;
      ST_RESTART: stateNext = ST_ARMED;
      default:    stateNext = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ARMED;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.clrCnt     = !armed || !enable || heartbeat || fire;
    strobe.incCnt     = tick;
    strobe.applyTrip  = (state == ST_FIRE);
    strobe.allowWrite = armed;
  end

  assign ctlRst       = (state == ST_FIRE);
  assign restartPulse = (state == ST_RESTART);
endmodule

// File: rtl/selfheal_wdog.sv
module selfheal_wdog
  import selfheal_pkg::*;
#(
  parameter int SHORT_PERIOD_TICKS = 1,
  parameter int LONG_PERIOD_TICKS  = 16,
  parameter int WINDOW_PERIODS     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             heartbeat,
  input  logic             longPeriod,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             ctlRst,
  output logic             restartPulse,
  output logic             irq
);
  dpStrobe_t strobe;
  logic atLast, enable;
  logic [REG_W-1:0] regView;

  selfheal_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .heartbeat(heartbeat),
    .enable(enable), .atLast(atLast), .strobe(strobe),
    .ctlRst(ctlRst), .restartPulse(restartPulse)
  );

  selfheal_dp #(
    .SHORT_PERIOD_TICKS(SHORT_PERIOD_TICKS),
    .LONG_PERIOD_TICKS(LONG_PERIOD_TICKS),
    .WINDOW_PERIODS(WINDOW_PERIODS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .longPeriod(longPeriod),
    .wrEn(wrEn), .wrData(wrData), .atLast(atLast), .enable(enable),
    .regView(regView)
  );

  assign rdData = regView;
  assign irq    = regView[FL_BIT];
endmodule

// File: rtl/selfheal_chk.sv
module selfheal_chk
  import selfheal_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [REG_W-1:0] rdData,
  input logic             ctlRst,
  input logic             restartPulse,
  input logic             irq
);
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rstN) ctlRst |=> !ctlRst); // R4
  AST_RESTART_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) ctlRst |=> restartPulse); // R4
  AST_NO_PULSE_OVERLAP: assert property (@(posedge clk) disable iff (!rstN) !(ctlRst && restartPulse)); // R4
  AST_TRIP_REGS: assert property (@(posedge clk) disable iff (!rstN) ctlRst |=> (rdData[ST_BIT] && rdData[EN_BIT] && !rdData[IE_BIT])); // R5
  AST_FLAG_FROM_IE: assert property (@(posedge clk) disable iff (!rstN) (ctlRst && rdData[IE_BIT]) |=> rdData[FL_BIT]); // R6
  AST_IRQ_ONLY_TRIP: assert property (@(posedge clk) disable iff (!rstN) $rose(irq) |-> $past(ctlRst)); // R6
  AST_FLAG_NO_WRITE_SET: assert property (@(posedge clk) disable iff (!rstN) $rose(rdData[FL_BIT]) |-> $past(ctlRst)); // R8
  AST_DISABLED_NO_TRIP: assert property (@(posedge clk) disable iff (!rstN) !rdData[EN_BIT] |=> !ctlRst); // R7
  AST_STATUS_ORDER: assert property (@(posedge clk) disable iff (!rstN) $fell(rdData[ST_BIT]) |-> !$past(rdData[FL_BIT])); // R9
endmodule

bind selfheal_wdog selfheal_chk u_chk (
  .clk(clk), .rstN(rstN), .rdData(rdData), .ctlRst(ctlRst),
  .restartPulse(restartPulse), .irq(irq)
);

// File: tb/selfheal_wdog_tb.sv
module selfheal_wdog_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, heartbeat = 1'b0, longPeriod = 1'b0, wrEn = 1'b0;
  logic [3:0] wrData = 4'h0;
  logic [3:0] rdData;
  logic ctlRst, restartPulse, irq;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  selfheal_wdog u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .heartbeat(heartbeat),
    .longPeriod(longPeriod), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .ctlRst(ctlRst), .restartPulse(restartPulse), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulseTick(bit hb = 1'b0);
    @(negedge clk); tick = 1'b1; heartbeat = hb;
    @(negedge clk); tick = 1'b0; heartbeat = 1'b0;
  endtask

  task automatic pulseHb();
    @(negedge clk); heartbeat = 1'b1;
    @(negedge clk); heartbeat = 1'b0;
  endtask

  task automatic writeReg(logic [3:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  // called right after the firing tick: checks both pulses
  task automatic expectTrip(string req);
    check({req, " ctlRst"}, ctlRst, 1);
    check({req, " restart early"}, restartPulse, 0);
    @(negedge clk);
    check("R4 ctlRst one cycle", ctlRst, 0);
    check("R4 restart follows", restartPulse, 1);
    @(negedge clk);
    check("R4 restart one cycle", restartPulse, 0);
  endtask

  task automatic testReset();
    check("R1 rdData", rdData, 4'b0001);
    check("R1 ctlRst", ctlRst, 0);
    check("R1 restart", restartPulse, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic testShortTimeout();
    pulseHb();
    pulseTick();
    check("R2 one tick no trip", ctlRst, 0);
    pulseTick();
    expectTrip("R2 short window");
    check("R5 regs after trip", rdData, 4'b0101);
    check("R6 no flag when ie=0", irq, 0);
  endtask

  task automatic testHbPriority();
    pulseTick();
    check("R3 first tick", ctlRst, 0);
    pulseTick(1'b1);
    check("R3 tick+hb", ctlRst, 0);
    pulseTick();
    check("R3 count cleared", ctlRst, 0);
    pulseTick();
    expectTrip("R3 trip after clear");
  endtask

  task automatic testFlagAndClear();
    writeReg(4'b0111);
    check("R9 write 1 keeps status", rdData, 4'b0111);
    pulseHb();
    pulseTick(); pulseTick();
    expectTrip("R6 trip with ie");
    check("R6 flag set, R5 ie cleared", rdData, 4'b1101);
    check("R6 irq", irq, 1);
    writeReg(4'b1001);
    check("R9 status held while flag set", rdData, 4'b1101);
    writeReg(4'b0101);
    check("R8 flag cleared", rdData, 4'b0101);
    check("R8 irq low", irq, 0);
    writeReg(4'b1001);
    check("R9 status cleared, R8 write 1 no set", rdData, 4'b0001);
  endtask

  task automatic testDisable();
    writeReg(4'b0000);
    check("R7 disabled", rdData, 4'b0000);
    for (int i = 0; i < 6; i++) begin
      pulseTick();
      check("R7 no trip while off", ctlRst, 0);
    end
    writeReg(4'b0001);
    pulseTick();
    check("R7 count from zero", ctlRst, 0);
    pulseTick();
    expectTrip("R7 trip after reenable");
  endtask

  task automatic testIgnoreDuringPulse();
    pulseHb();
    pulseTick(); pulseTick();
    check("R10 trip", ctlRst, 1);
    tick = 1'b1; heartbeat = 1'b1;
    @(negedge clk);
    check("R10 restart cycle", restartPulse, 1);
    @(negedge clk);
    tick = 1'b0; heartbeat = 1'b0;
    pulseTick();
    check("R10 window restarted", ctlRst, 0);
    pulseTick();
    expectTrip("R10 trip after restart");
  endtask

  task automatic testLongWindow();
    pulseHb();
    @(negedge clk); longPeriod = 1'b1;
    for (int i = 0; i < 31; i++) begin
      pulseTick();
      if (ctlRst !== 1'b0) check("R2 long early trip", ctlRst, 0);
    end
    check("R2 31 ticks no trip", ctlRst, 0);
    pulseTick();
    expectTrip("R2 long window");
    @(negedge clk); longPeriod = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testShortTimeout();
    testHbPriority();
    testFlagAndClear();
    testDisable();
    testIgnoreDuringPulse();
    testLongWindow();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end
endmodule